// File: doc/BRIEF.md
# Serial Register-Access Slave with Deferred Readback

This block is the serial front end of a register-mapped device. A host opens a frame by pulling an active-low select low. It then clocks an instruction byte and a 16-bit data word into the block, most significant bit first. The serial clock may run all the time or only during frames. The block samples the select, clock and data lines in its own system clock domain through two-flop synchronizers. It decodes each frame when select is released and turns it into single-cycle write or read-request pulses on a register-file port.

A read command does not return data in the same frame. The register file answers one system clock after the read request. The word is held and shifted out during the next frame, behind an echo of the instruction byte that asked for it. A frame that is too short is dropped. A frame that is too long is cut to its first 24 bits, or its first 32 bits in error-check mode. In that mode the trailing byte is captured and presented unchecked. The serial output is enabled only while select is low and readback is enabled. A configuration input picks the clock edge on which output bits change.

Top module: `sreg_slave`

## Requirements
- R1: After reset there are no write, read-request or frame-valid pulses, the output enable is low, the check output is zero, and the first frame shifts out 24 zero bits.
- R2: A valid frame whose bit 23 is 0 yields exactly one write pulse after select rises, carrying address bits 21:16 and data bits 15:0; bit 22 has no effect on the write.
- R3: A valid frame whose bit 23 is 1 yields exactly one read-request pulse carrying address bits 21:16 and no write pulse; the register file answers on the following system clock.
- R4: During the frame after a valid frame, bits 23:16 of the output echo bits 23:16 of that frame, and bits 15:0 carry the read word after a read, or zero after a write.
- R5: A frame with fewer falling serial-clock edges than the required length gives no pulse of any kind and leaves the echoed output unchanged.
- R6: In a frame longer than the required length, the bits after the first 24 (or 32) have no effect on the decoded command or the check byte.
- R7: With the check-mode input high at frame start, the required length is 32; the first 24 bits decode as in R2 and R3, bits 7:0 appear on the check output, and a single frame-valid pulse is given.
- R8: The serial output enable is high only while select is low and the readback-enable input is high.
- R9: With the launch input low, output bit k is valid from the k-th falling clock edge (bit 0 from select low). With it high, output bits change only on rising edges that follow the first falling edge.
- R10: Clock and data activity while select is high causes no pulse and does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk_i | input | 1 | Serial clock |
| spi_cs_n_i | input | 1 | Active-low frame select |
| spi_sdi_i | input | 1 | Serial data in |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdo_oe_o | output | 1 | Output enable for the serial data out driver |
| sdo_en_i | input | 1 | Readback enable |
| launch_rise_i | input | 1 | 1: output changes on rising edges, 0: on falling edges |
| chk_mode_i | input | 1 | 1: 32-bit frames with check byte |
| reg_wr_o | output | 1 | Register write pulse |
| reg_rd_o | output | 1 | Register read-request pulse |
| reg_addr_o | output | 6 | Register address |
| reg_wdata_o | output | 16 | Write data |
| reg_rdata_i | input | 16 | Read data, valid one clock after the read request |
| frame_ok_o | output | 1 | Pulse for every frame of valid length |
| chk_o | output | 8 | Check byte of the last valid 32-bit frame |

## Verification
Frames are drawn at random as writes or reads, at random addresses and data, in both lengths and both launch modes. They include exact-length, truncated-long and short frames. A read that follows writes to the same address shows whether the readback word comes from the register file or from stale state. Frames that follow short ones, or that follow clock toggling with select high, show whether discarded traffic leaks into the echo or into the decoder. Sampling the output before both clock edges tells the two launch modes apart, and toggling readback enable exposes the output enable.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    parameter int ADDR_W = 6;
    parameter int DATA_W = 16;
    parameter int CHK_W  = 8;
    parameter int SYNC_N = 2;

    localparam int HDR_W  = ADDR_W + 2;
    localparam int WORD_W = HDR_W + DATA_W;
    localparam int LONG_W = WORD_W + CHK_W;
    localparam int CNT_W  = $clog2(LONG_W + 1);

    typedef struct packed {
        logic              rnw;
        logic              spare;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic active;
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sdi;
    } lnk_t;

    function automatic logic [CNT_W-1:0] need_bits(input logic long_mode);
        return long_mode ? CNT_W'(LONG_W) : CNT_W'(WORD_W);
    endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL[b]}};
                else     chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sreg_edge.sv
module sreg_edge
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_s,
    input  logic sclk_s,
    input  logic sdi_s,
    output lnk_t lnk
);
    logic cs_q, sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    always_comb begin
        lnk.active = ~cs_s;
        lnk.start  = cs_q & ~cs_s;
        lnk.stop   = ~cs_q & cs_s;
        lnk.rise   = ~cs_s & ~sclk_q & sclk_s;
        lnk.fall   = ~cs_s & sclk_q & ~sclk_s;
        lnk.sdi    = sdi_s;
    end

    // R10: no serial clock event is reported while select is high
    p_idle_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        cs_s |-> !(lnk.rise || lnk.fall));
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lnk_t              lnk,
    input  logic              chk_mode_i,
    output logic              wr_o,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              frame_ok_o,
    output logic [CHK_W-1:0]  chk_o,
    output logic [HDR_W-1:0]  hdr_o
);
    logic [LONG_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              long_q;
    logic [CNT_W-1:0]  need;
    logic              done;
    cmd_t              cmd;

    assign need = need_bits(long_q);
    assign done = lnk.stop && (cnt == need);

    always_comb begin
        if (long_q) cmd = cmd_t'(sh[LONG_W-1:CHK_W]);
        else        cmd = cmd_t'(sh[WORD_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '0;
            cnt        <= '0;
            long_q     <= 1'b0;
            wr_o       <= 1'b0;
            rd_o       <= 1'b0;
            frame_ok_o <= 1'b0;
            addr_o     <= '0;
            wdata_o    <= '0;
            chk_o      <= '0;
            hdr_o      <= '0;
        end else begin
            wr_o       <= 1'b0;
            rd_o       <= 1'b0;
            frame_ok_o <= 1'b0;
            if (lnk.start) begin
                cnt    <= '0;
                long_q <= chk_mode_i;
            end else if (lnk.fall && (cnt < need)) begin
                sh  <= {sh[LONG_W-2:0], lnk.sdi};
                cnt <= cnt + 1'b1;
            end
            if (done) begin
                frame_ok_o <= 1'b1;
                wr_o       <= ~cmd.rnw;
                rd_o       <= cmd.rnw;
                addr_o     <= cmd.addr;
                hdr_o      <= {cmd.rnw, cmd.spare, cmd.addr};
                if (!cmd.rnw) wdata_o <= cmd.data;
                if (long_q)   chk_o   <= sh[CHK_W-1:0];
            end
        end
    end

    // R3: a frame is either a write or a read, never both
    p_wr_rd_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_o && rd_o));
    // R2: write strobe lasts one cycle
    p_wr_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        wr_o |=> !wr_o);
    // R3: read request lasts one cycle
    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        rd_o |=> !rd_o);
    // R6: bit counter never passes the frame length
    p_cnt_cap_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= need);
    // R5: a short frame gives no frame-valid pulse
    p_short_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (lnk.stop && (cnt != need)) |=> !frame_ok_o);
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lnk_t              lnk,
    input  logic              sdo_en_i,
    input  logic              launch_rise_i,
    input  logic              frame_ok_i,
    input  logic [HDR_W-1:0]  hdr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    logic [HDR_W-1:0]  echo_hdr;
    logic [DATA_W-1:0] echo_data;
    logic              rd_pend;
    logic [WORD_W-1:0] txs;
    logic              fall_seen;
    logic              shift_now;

    assign shift_now = launch_rise_i ? (lnk.rise && fall_seen) : lnk.fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_hdr  <= '0;
            echo_data <= '0;
            rd_pend   <= 1'b0;
        end else begin
            rd_pend <= 1'b0;
            if (frame_ok_i) begin
                echo_hdr  <= hdr_i;
                echo_data <= '0;
                rd_pend   <= hdr_i[HDR_W-1];
            end else if (rd_pend) begin
                echo_data <= rdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txs       <= '0;
            fall_seen <= 1'b0;
        end else if (lnk.start) begin
            txs       <= {echo_hdr, echo_data};
            fall_seen <= 1'b0;
        end else begin
            if (lnk.fall) fall_seen <= 1'b1;
            if (shift_now) txs <= {txs[WORD_W-2:0], 1'b0};
        end
    end

    assign sdo_o    = txs[WORD_W-1];
    assign sdo_oe_o = sdo_en_i & lnk.active;

    // R9: the output shifter moves only on a serial clock event or frame start
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!lnk.start && !lnk.fall && !lnk.rise) |=> $stable(txs));
    // R9: in rising-launch mode the first rising edge does not shift
    p_first_rise_r9: assert property (@(posedge clk) disable iff (rst)
        (launch_rise_i && lnk.rise && !fall_seen && !lnk.start) |=> $stable(txs));
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_sdi_i,
    output logic              spi_sdo_o,
    output logic              spi_sdo_oe_o,
    input  logic              sdo_en_i,
    input  logic              launch_rise_i,
    input  logic              chk_mode_i,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              frame_ok_o,
    output logic [CHK_W-1:0]  chk_o
);
    logic [2:0]       pins_s;
    lnk_t             lnk;
    logic [HDR_W-1:0] hdr;

    sreg_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n_i, spi_sclk_i, spi_sdi_i}),
        .q   (pins_s)
    );

    sreg_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .cs_s   (pins_s[2]),
        .sclk_s (pins_s[1]),
        .sdi_s  (pins_s[0]),
        .lnk    (lnk)
    );

    sreg_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .lnk        (lnk),
        .chk_mode_i (chk_mode_i),
        .wr_o       (reg_wr_o),
        .rd_o       (reg_rd_o),
        .addr_o     (reg_addr_o),
        .wdata_o    (reg_wdata_o),
        .frame_ok_o (frame_ok_o),
        .chk_o      (chk_o),
        .hdr_o      (hdr)
    );

    sreg_tx u_tx (
        .clk           (clk),
        .rst           (rst),
        .lnk           (lnk),
        .sdo_en_i      (sdo_en_i),
        .launch_rise_i (launch_rise_i),
        .frame_ok_i    (frame_ok_o),
        .hdr_i         (hdr),
        .rdata_i       (reg_rdata_i),
        .sdo_o         (spi_sdo_o),
        .sdo_oe_o      (spi_sdo_oe_o)
    );

    // R8: output driver is off whenever select is high at the pins' synchronized view
    p_oe_idle_r8: assert property (@(posedge clk) disable iff (rst)
        pins_s[2] |-> !spi_sdo_oe_o);
endmodule

// File: tb/sreg_slave_tb.sv
module sreg_slave_tb_top;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic        sdo, sdo_oe;
    logic        sdo_en = 1'b1, launch_rise = 1'b0, chk_mode = 1'b0;
    logic        reg_wr, reg_rd, frame_ok;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [7:0]  chk;

    int tests = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0, ok_cnt = 0;
    logic [5:0]  last_waddr, last_raddr;
    logic [15:0] last_wdata;
    logic [15:0] rf  [64];
    logic [15:0] ref_mem [64];
    logic [23:0] exp_echo = '0;

    always #2 clk = ~clk;

    sreg_slave dut_i (
        .clk(clk), .rst(rst), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_sdi_i(sdi),
        .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe), .sdo_en_i(sdo_en),
        .launch_rise_i(launch_rise), .chk_mode_i(chk_mode),
        .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
        .frame_ok_o(frame_ok), .chk_o(chk)
    );

    // register file with one-cycle read latency, plus pulse monitor
    always @(posedge clk) begin
        if (reg_wr) begin
            rf[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1; last_waddr <= reg_addr; last_wdata <= reg_wdata;
        end
        if (reg_rd) begin
            reg_rdata <= rf[reg_addr];
            rd_cnt <= rd_cnt + 1; last_raddr <= reg_addr;
        end
        if (frame_ok) ok_cnt <= ok_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] rise_view(input logic [23:0] w);
        return {w[23], w[23:1]};
    endfunction

    task automatic frame(input logic rnw, input logic spare, input logic [5:0] addr,
                         input logic [15:0] data, input logic [7:0] cbyte,
                         input bit long_m, input int nbits);
        logic [39:0] st, pr, pf;
        logic        oe_mid;
        int          len;
        bit          valid;
        logic [23:0] mask, exp_pr;
        st = {$urandom, 8'($urandom)};
        st[39:16] = {rnw, spare, addr, data};
        if (long_m) st[15:8] = cbyte;
        pr = '0; pf = '0; oe_mid = 1'b0;
        chk_mode = long_m;
        wr_cnt = 0; rd_cnt = 0; ok_cnt = 0;
        tick(2);
        cs_n = 1'b0; tick(HALF);
        for (int k = 0; k < nbits; k++) begin
            pr[39-k] = sdo; sdi = st[39-k]; sclk = 1'b1; tick(HALF);
            pf[39-k] = sdo; if (k == 0) oe_mid = sdo_oe;
            sclk = 1'b0; tick(HALF);
        end
        cs_n = 1'b1; tick(12);
        len = long_m ? 32 : 24;
        valid = (nbits >= len);
        // R8: enable follows readback enable while select is low, off when high
        check("R8 oe in frame", {31'd0, oe_mid}, {31'd0, sdo_en});
        check("R8 oe idle", {31'd0, sdo_oe}, 32'd0);
        if (sdo_en) begin
            mask = (nbits >= 24) ? 24'hFFFFFF : ~(24'hFFFFFF >> nbits);
            exp_pr = launch_rise ? rise_view(exp_echo) : exp_echo;
            check("R4 R9 echo at pre-fall", {8'd0, pf[39:16] & mask}, {8'd0, exp_echo & mask});
            check("R9 launch edge at pre-rise", {8'd0, pr[39:16] & mask}, {8'd0, exp_pr & mask});
        end
        if (!valid) begin
            check("R5 short no write", wr_cnt, 0);
            check("R5 short no read", rd_cnt, 0);
            check("R5 short no frame_ok", ok_cnt, 0);
        end else begin
            check("R7 one frame_ok", ok_cnt, 1);
            if (!rnw) begin
                check("R2 one write", wr_cnt, 1);
                check("R3 no read on write", rd_cnt, 0);
                check("R2 R6 write addr", {26'd0, last_waddr}, {26'd0, addr});
                check("R2 R6 write data", {16'd0, last_wdata}, {16'd0, data});
                ref_mem[addr] = data;
            end else begin
                check("R3 one read", rd_cnt, 1);
                check("R3 no write on read", wr_cnt, 0);
                check("R3 read addr", {26'd0, last_raddr}, {26'd0, addr});
            end
            if (long_m) check("R7 R6 check byte", {24'd0, chk}, {24'd0, cbyte});
            exp_echo = {rnw, spare, addr, rnw ? ref_mem[addr] : 16'h0};
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) begin rf[i] = '0; ref_mem[i] = '0; end
        tick(6);
        rst = 1'b0;
        tick(4);
        // R1: reset state
        check("R1 oe after reset", {31'd0, sdo_oe}, 32'd0);
        check("R1 chk after reset", {24'd0, chk}, 32'd0);
        check("R1 no pulses", {29'd0, reg_wr, reg_rd, frame_ok}, 32'd0);
        // R1: first frame shifts zeros (exp_echo is zero), writes 0x5
        frame(1'b0, 1'b1, 6'h05, 16'hA5C3, 8'h00, 0, 24);
        // R3 then R4: readback of written word
        frame(1'b1, 1'b0, 6'h05, 16'hFFFF, 8'h00, 0, 24);
        frame(1'b0, 1'b0, 6'h3F, 16'h1234, 8'h00, 0, 24);
        // R5: short frames leave echo untouched
        frame(1'b0, 1'b0, 6'h05, 16'h0000, 8'h00, 0, 23);
        frame(1'b1, 1'b0, 6'h3F, 16'h0000, 8'h00, 1, 31);
        // R7: 32-bit mode, R6: overlong
        frame(1'b1, 1'b1, 6'h3F, 16'h0F0F, 8'h9C, 1, 32);
        frame(1'b0, 1'b0, 6'h00, 16'hFFFF, 8'h61, 1, 37);
        frame(1'b1, 1'b0, 6'h00, 16'h0000, 8'h00, 0, 30);
        // R10: clock and data activity with select high
        wr_cnt = 0; rd_cnt = 0; ok_cnt = 0;
        for (int k = 0; k < 30; k++) begin
            sdi = k[0]; sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
        end
        tick(8);
        check("R10 idle no pulses", wr_cnt + rd_cnt + ok_cnt, 0);
        frame(1'b1, 1'b0, 6'h05, 16'h0000, 8'h00, 0, 24);
        // R9: rising launch, R8: readback disabled
        launch_rise = 1'b1;
        frame(1'b0, 1'b1, 6'h11, 16'hBEEF, 8'h00, 0, 24);
        sdo_en = 1'b0;
        frame(1'b1, 1'b0, 6'h11, 16'h0000, 8'h00, 0, 24);
        sdo_en = 1'b1;
        frame(1'b0, 1'b0, 6'h12, 16'h0001, 8'h00, 0, 24);
        // random mix
        for (int n = 0; n < 48; n++) begin
            bit lm;
            int len, nb, sel;
            lm = 1'($urandom);
            len = lm ? 32 : 24;
            sel = $urandom % 8;
            if (sel == 0)      nb = len - 1 - ($urandom % 4);
            else if (sel == 1) nb = len + 1 + ($urandom % 6);
            else               nb = len;
            launch_rise = 1'($urandom);
            sdo_en = (($urandom % 6) != 0);
            frame(1'($urandom), 1'($urandom), 6'($urandom % 8), 16'($urandom),
                  8'($urandom), lm, nb);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule